// File: doc/BRIEF.md
# Multiplexed Display Row Scan Sequencer

This block drives the row-select lines of a time-multiplexed LED matrix. It also tells the column pulse-width stage which display-memory row to fetch and where it stands inside the current scan slot. Rows can be stepped by an internal counter over either 8 or 16 rows, one row per scan slot. Alternatively, an outside controller can name the active row directly through a 4-bit index.

A scan slot has three phases. A blanking mask of `MASK_CLKS` clocks comes first. Two pulse-width windows of `PW_CLKS` clocks each follow it. With the defaults the slot is 2109 clocks long, so a full 8-row frame takes 16872 clocks and a 16-row frame takes 33744.

A stall watchdog watches the decoded row selection. If that selection stays frozen for `WDOG_CLKS` clocks (3,000,000 by default, about 0.3 s at 10 MHz), the watchdog forces every row dark. It releases the display once the selection moves again.

Top module: `rsq_row_scan`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following clock shows `row_on` all zero, `mem_row` 0, `frame_start` 0, `blank` 0, `slot_phase` 0 and `phase_cnt` 0.
- R2: With `ext_mode` low and `rows16` low, the rows light in the order `row_on` bit 0 to bit 7 and then return to bit 0. Each row stays lit for exactly one slot, and `mem_row` carries the index of the lit bit.
- R3: With `ext_mode` low and `rows16` high, the same sequencing covers bits 0 to 15.
- R4: With `ext_mode` high, one clock after `ext_row` is sampled, `row_on` has only bit `ext_row` set (0 selects bit 0, 15 selects bit 15) and `mem_row` equals `ext_row`, whatever the level of `rows16`.
- R5: A slot lasts `MASK_CLKS + 2*PW_CLKS` clocks. `slot_phase` reads 0 for the mask, 1 for the first window and 2 for the second window. `phase_cnt` counts from 0 inside each phase. An internal row change appears on the first mask clock.
- R6: `frame_start` is high for exactly one clock. That clock is the one in which the internal scan returns to bit 0 after its last row. The signal never rises in external mode.
- R7: At most one bit of `row_on` is ever set. Out of reset and not blanked, exactly one bit is set.
- R8: If the decoded row selection has not changed for `WDOG_CLKS` consecutive clocks, `blank` rises and `row_on` reads zero. After the selection changes, the first clock of the new row is still dark, and `blank` clears on the next clock.
- R9: If `rows16` falls while the internal counter is above row 8, the counter wraps to bit 0 at the end of that slot. Leaving external mode restarts the internal scan at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_mode | input | 1 | 1: row chosen by `ext_row`; 0: internal sequencing |
| rows16 | input | 1 | Internal scan length: 0 for 8 rows, 1 for 16 rows |
| ext_row | input | ROW_W (4) | Externally chosen row index |
| row_on | output | NUM_ROWS (16) | One-hot row select, active high |
| mem_row | output | ROW_W (4) | Display-memory row to feed the columns |
| slot_phase | output | 2 | 0 mask, 1 first window, 2 second window |
| phase_cnt | output | PCW (10) | Clock position inside the current phase |
| frame_start | output | 1 | One-clock pulse at the start of an internal frame |
| blank | output | 1 | Watchdog has forced the display dark |

## Verification
The bench goes after the corner cases where a wrong design shows itself at the ports. At the 8-row wrap, an off-by-one counter would light bit 8 or pulse `frame_start` one slot late. Dropping `rows16` while row 12 is lit checks that the counter wraps instead of running on to bit 15. An external index of 15 with `rows16` low would be masked by a decoder that wrongly applies the internal length limit. Holding `ext_row` fixed until the watchdog fires, then moving it, checks both the timeout count and the one-clock dark gap on release. A watchdog that restarted late or never cleared would leave the rows dark.

// File: rtl/rsq_pkg.sv
// Package rsq_pkg
// Shared types for the row scan sequencer: the phase encoding of a scan slot.
// Assumes: the encoding is visible at the top port as a plain 2-bit value.
package rsq_pkg;
    typedef enum logic [1:0] {
        PH_MASK   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } slot_phase_e;
endpackage

// File: rtl/rsq_slot_timer.sv
// Module rsq_slot_timer
// Walks through one scan slot as three phases: a blanking mask, then two
// pulse-width windows of equal length. Flags the last clock of the slot.
// Assumes: MASK_CLKS and PW_CLKS are at least 1 and fit into PCW bits.
module rsq_slot_timer
    import rsq_pkg::*;
#(
    parameter int MASK_CLKS = 63,
    parameter int PW_CLKS   = 1023,
    parameter int PCW       = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    output slot_phase_e    phase,
    output logic [PCW-1:0] phase_cnt,
    output logic           slot_last
);
    localparam logic [PCW-1:0] MASK_END = PCW'(MASK_CLKS - 1);
    localparam logic [PCW-1:0] PW_END   = PCW'(PW_CLKS - 1);

    slot_phase_e    ph_q;
    logic [PCW-1:0] cnt_q;
    logic [PCW-1:0] span_end;
    logic           phase_end;

    // Last count value of the phase in progress.
    always_comb begin
        span_end  = (ph_q == PH_MASK) ? MASK_END : PW_END;
        phase_end = (cnt_q == span_end);
    end

    // Advance the in-phase count and step to the next phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_MASK;
            cnt_q <= '0;
        end else if (phase_end) begin
            cnt_q <= '0;
            case (ph_q)
                PH_MASK:  ph_q <= PH_FIRST;
                PH_FIRST: ph_q <= PH_SECOND;
                default:  ph_q <= PH_MASK;
            endcase
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase     = ph_q;
    assign phase_cnt = cnt_q;
    assign slot_last = phase_end && (ph_q == PH_SECOND);

    assert_mask_to_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_MASK && cnt_q == MASK_END) |=> (ph_q == PH_FIRST && cnt_q == '0));

    assert_phase_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != 2'd3));

    assert_slot_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> (ph_q == PH_MASK && cnt_q == '0));
endmodule

// File: rtl/rsq_row_counter.sv
// Module rsq_row_counter
// Internal row index: steps once per slot over 8 or 16 rows and wraps to the
// first row, raising a one-clock frame pulse on the wrap. Held at row 0 in
// external mode. Also exposes the next index so the decode lines up with the
// first clock of a slot.
// Assumes: NUM_ROWS is even; half of it is the short scan length.
module rsq_row_counter #(
    parameter int NUM_ROWS = 16,
    parameter int ROW_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             rows16,
    input  logic             slot_last,
    output logic [ROW_W-1:0] idx_next,
    output logic             frame_start
);
    localparam logic [ROW_W-1:0] LAST_LONG  = ROW_W'(NUM_ROWS - 1);
    localparam logic [ROW_W-1:0] LAST_SHORT = ROW_W'(NUM_ROWS / 2 - 1);

    logic [ROW_W-1:0] idx_q;
    logic [ROW_W-1:0] last_row;
    logic             at_end;

    // Next index: hold, step, wrap, or park at row 0 in external mode.
    always_comb begin
        last_row = rows16 ? LAST_LONG : LAST_SHORT;
        at_end   = (idx_q >= last_row);
        if (ext_mode)
            idx_next = '0;
        else if (slot_last)
            idx_next = at_end ? '0 : idx_q + 1'b1;
        else
            idx_next = idx_q;
    end

    // Hold the index and register the frame pulse on an internal wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            frame_start <= 1'b0;
        end else begin
            idx_q       <= idx_next;
            frame_start <= !ext_mode && slot_last && at_end;
        end
    end

    assert_frame_at_row0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (idx_q == '0));

    assert_hold_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_last && !ext_mode) |=> $stable(idx_q));

    assert_ext_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> (idx_q == '0 && !frame_start));
endmodule

// File: rtl/rsq_row_decode.sv
// Module rsq_row_decode
// Registers the selected row index and its one-hot decode.
// Assumes: every index value below NUM_ROWS is a legal row.
module rsq_row_decode #(
    parameter int NUM_ROWS = 16,
    parameter int ROW_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROW_W-1:0]    sel_idx,
    output logic [NUM_ROWS-1:0] row_q,
    output logic [ROW_W-1:0]    idx_q
);
    logic [NUM_ROWS-1:0] row_d;

    // One comparator per row line.
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        assign row_d[g] = (sel_idx == ROW_W'(g));
    end

    // Register the decode and the index; all rows dark in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            idx_q <= '0;
        end else begin
            row_q <= row_d;
            idx_q <= sel_idx;
        end
    end

    assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $onehot(row_q));

    assert_line_matches_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> row_q[idx_q]);
endmodule

// File: rtl/rsq_stall_watch.sv
// Module rsq_stall_watch
// Counts clocks since the row selection last changed and asserts blank once
// the count reaches WDOG_CLKS. Any change restarts the count.
// Assumes: the monitored selection is the registered one-hot decode.
module rsq_stall_watch #(
    parameter int NUM_ROWS  = 16,
    parameter int WDOG_CLKS = 3000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] row_q,
    output logic                blank
);
    localparam int TW = $clog2(WDOG_CLKS + 1);
    localparam logic [TW-1:0] LIMIT = TW'(WDOG_CLKS);

    logic [NUM_ROWS-1:0] row_prev;
    logic [TW-1:0]       stall_q;
    logic                moved;

    // Detect a change in the selection since the previous clock.
    always_comb moved = (row_q != row_prev);

    // Remember the selection and count idle clocks, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_prev <= '0;
            stall_q  <= '0;
        end else begin
            row_prev <= row_q;
            if (moved)
                stall_q <= '0;
            else if (stall_q != LIMIT)
                stall_q <= stall_q + 1'b1;
        end
    end

    assign blank = (stall_q == LIMIT);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        moved |=> !blank);

    assert_rise_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank) |-> $stable(row_q));
endmodule

// File: rtl/rsq_row_scan.sv
// Module rsq_row_scan (top)
// Row scan sequencer: slot timer, internal row counter, external/internal
// select, registered one-hot decode and a stall watchdog that darkens rows.
// Assumes: a single clock domain; ext_row and mode pins are synchronous.
module rsq_row_scan
    import rsq_pkg::*;
#(
    parameter int  NUM_ROWS  = 16,
    parameter int  MASK_CLKS = 63,
    parameter int  PW_CLKS   = 1023,
    parameter int  WDOG_CLKS = 3000000,
    localparam int ROW_W     = $clog2(NUM_ROWS),
    localparam int MAXP      = (MASK_CLKS > PW_CLKS) ? MASK_CLKS : PW_CLKS,
    localparam int PCW       = (MAXP > 1) ? $clog2(MAXP) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_mode,
    input  logic                rows16,
    input  logic [ROW_W-1:0]    ext_row,
    output logic [NUM_ROWS-1:0] row_on,
    output logic [ROW_W-1:0]    mem_row,
    output logic [1:0]          slot_phase,
    output logic [PCW-1:0]      phase_cnt,
    output logic                frame_start,
    output logic                blank
);
    slot_phase_e         phase;
    logic                slot_last;
    logic [ROW_W-1:0]    int_next;
    logic [ROW_W-1:0]    sel_idx;
    logic [NUM_ROWS-1:0] row_q;

    rsq_slot_timer #(
        .MASK_CLKS (MASK_CLKS),
        .PW_CLKS   (PW_CLKS),
        .PCW       (PCW)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .phase_cnt (phase_cnt),
        .slot_last (slot_last)
    );

    rsq_row_counter #(
        .NUM_ROWS (NUM_ROWS),
        .ROW_W    (ROW_W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_mode    (ext_mode),
        .rows16      (rows16),
        .slot_last   (slot_last),
        .idx_next    (int_next),
        .frame_start (frame_start)
    );

    // Choose the row source: the outside index or the internal counter.
    always_comb sel_idx = ext_mode ? ext_row : int_next;

    rsq_row_decode #(
        .NUM_ROWS (NUM_ROWS),
        .ROW_W    (ROW_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_idx (sel_idx),
        .row_q   (row_q),
        .idx_q   (mem_row)
    );

    rsq_stall_watch #(
        .NUM_ROWS  (NUM_ROWS),
        .WDOG_CLKS (WDOG_CLKS)
    ) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .row_q (row_q),
        .blank (blank)
    );

    // Darken all rows while the watchdog holds blank.
    always_comb row_on = blank ? '0 : row_q;

    assign slot_phase = phase;

    assert_reset_dark_R1: assert property (@(posedge clk)
        !rst_n |=> (row_on == '0 && !frame_start && !blank && mem_row == '0));

    assert_ext_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> (mem_row == $past(ext_row)));

    assert_at_most_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_on));

    assert_blank_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (row_on == '0));
endmodule

// File: tb/test_rsq_row_scan.sv
module test_rsq_row_scan;
    localparam int M  = 3;
    localparam int P  = 5;
    localparam int TO = 40;
    localparam int SL = M + 2 * P;

    typedef struct {
        bit rst;
        bit ext;
        bit r16;
        int row;
        int idx;
        int ph;
        int pc;
        int frm;
        int blk;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic        rows16 = 1'b0;
    logic [3:0]  ext_row = 4'd0;
    logic [15:0] row_on;
    logic [3:0]  mem_row;
    logic [1:0]  slot_phase;
    logic [2:0]  phase_cnt;
    logic        frame_start;
    logic        blank;

    int compared = 0;
    int mismatched = 0;
    exp_t q[$];

    // Reference state, updated from the requirements at each rising edge.
    int m_slot = 0, m_cnt = 0, m_row = 0, m_prev = 0, m_idx = 0, m_stall = 0, m_frm = 0;

    rsq_row_scan #(.NUM_ROWS(16), .MASK_CLKS(M), .PW_CLKS(P), .WDOG_CLKS(TO)) i_rsq_row_scan (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .rows16(rows16), .ext_row(ext_row),
        .row_on(row_on), .mem_row(mem_row), .slot_phase(slot_phase), .phase_cnt(phase_cnt),
        .frame_start(frame_start), .blank(blank));

    always #2.5 clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Driver side of the scoreboard: predict each cycle and queue it.
    always @(posedge clk) begin
        exp_t e;
        int last;
        bit sl, chg;
        if (!rst_n) begin
            m_slot = 0; m_cnt = 0; m_row = 0; m_prev = 0; m_idx = 0; m_stall = 0; m_frm = 0;
        end else begin
            sl = (m_slot == SL - 1);
            last = rows16 ? 15 : 7;
            chg = (m_row != m_prev);
            m_prev = m_row;
            m_stall = chg ? 0 : ((m_stall == TO) ? TO : m_stall + 1);
            m_frm = (!ext_mode && sl && m_cnt >= last) ? 1 : 0;
            if (ext_mode) m_cnt = 0;
            else if (sl) m_cnt = (m_cnt >= last) ? 0 : m_cnt + 1;
            m_idx = ext_mode ? int'(ext_row) : m_cnt;
            m_row = 1 << m_idx;
            m_slot = sl ? 0 : m_slot + 1;
        end
        e.rst = !rst_n;
        e.ext = ext_mode;
        e.r16 = rows16;
        e.blk = (m_stall == TO) ? 1 : 0;
        e.row = e.blk ? 0 : m_row;
        e.idx = m_idx;
        e.frm = m_frm;
        if (m_slot < M) begin e.ph = 0; e.pc = m_slot; end
        else if (m_slot < M + P) begin e.ph = 1; e.pc = m_slot - M; end
        else begin e.ph = 2; e.pc = m_slot - M - P; end
        q.push_back(e);
    end

    // Monitor side: pop the prediction and compare away from the clock edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            string tr;
            e = q.pop_front();
            tr = e.rst ? "R1" : (e.blk ? "R8" : (e.ext ? "R4" : (e.r16 ? "R3" : "R2")));
            chk(tr, "row_on", int'(row_on), e.row);
            chk(tr, "mem_row", int'(mem_row), e.idx);
            chk(e.rst ? "R1" : "R5", "slot_phase", int'(slot_phase), e.ph);
            chk(e.rst ? "R1" : "R5", "phase_cnt", int'(phase_cnt), e.pc);
            chk(e.rst ? "R1" : "R6", "frame_start", int'(frame_start), e.frm);
            chk(e.rst ? "R1" : "R8", "blank", int'(blank), e.blk);
            chk("R7", "row_on popcount<=1", ($countones(row_on) <= 1) ? 1 : 0, 1);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int guard;
        logic [15:0] held;
        cycles(4);
        chk("R1", "row_on in reset", int'(row_on), 0);
        rst_n = 1'b1;
        cycles(2 * 8 * SL + 20);          // R2: eight-row scan, two frames
        rows16 = 1'b1;
        cycles(16 * SL + 60);             // R3: sixteen-row scan
        // R9: shorten the scan while row 12 is lit.
        guard = 0;
        while (!row_on[11] && guard < 400) begin cycles(1); guard++; end
        rows16 = 1'b0;
        held = row_on;
        guard = 0;
        while (row_on == held && guard < 100) begin cycles(1); guard++; end
        chk("R9", "wrap after shortening", int'(row_on), 1);
        cycles(40);
        // R4: external indices, including 15 with the short scan selected.
        ext_mode = 1'b1;
        ext_row = 4'd0;  cycles(6);
        ext_row = 4'd15; cycles(6);
        chk("R4", "ext 15 row_on", int'(row_on), 32768);
        ext_row = 4'd5;  cycles(6);
        ext_row = 4'd10; cycles(6);
        // R8: hold the index until the watchdog fires.
        ext_row = 4'd9;  cycles(TO + 10);
        chk("R8", "blank after stall", int'(blank), 1);
        chk("R8", "rows dark after stall", int'(row_on), 0);
        ext_row = 4'd3;
        cycles(1);
        chk("R8", "first clock of new row dark", int'(row_on), 0);
        cycles(1);
        chk("R8", "display back", int'(row_on), 8);
        cycles(10);
        // R9: back to internal scan restarts at row 1.
        ext_mode = 1'b0;
        cycles(1);
        chk("R9", "restart at row 1", int'(row_on), 1);
        cycles(8 * SL + 10);
        rst_n = 1'b0;
        cycles(3);
        chk("R1", "row_on after mid-run reset", int'(row_on), 0);
        rst_n = 1'b1;
        cycles(SL + 5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule